// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small microcontroller core in a fixed set of eight hardware slots. Software can neither read nor write these slots, or the level indicator that selects one of them. A subroutine call or an accepted interrupt stores the current program counter. A return, whether from a subroutine or from an interrupt, hands back the most recently stored address on `ret_pc_o`, one clock after the request.

The block also decides when an interrupt may be accepted. An interrupt request that arrives while all eight slots are occupied is not acknowledged. It is held internally and is acknowledged on the first free cycle after a return has released a slot. A subroutine call, in contrast, is never refused. A call on a full stack drops the oldest stored address, so the eight newest remain. The index is circular and is paired with an occupancy count, so an overwrite moves no entries.

The core drives one request per cycle at most in normal use. Collisions are still resolved in a fixed order: a return beats a call, and a call beats an interrupt, which then waits as pending.

Top module: `ret_addr_stack`

## Requirements
- R1: After synchronous reset, `empty_o`=1, `full_o`=0, `ret_pc_o`=0 and `irq_ack_o`=0 while no request is driven.
- R2: Addresses stored by `call_i` come back on `ret_pc_o` in last-in first-out order. Each value is visible from the clock edge that samples `ret_i`.
- R3: `empty_o` falls after the first store. `full_o` rises after the eighth store without an intervening return.
- R4: A call on a full stack stores the new address and discards the oldest one. `full_o` stays 1, and the following eight returns yield the eight newest addresses, newest first.
- R5: An interrupt request with free space, and with no call or return in the same cycle, is acknowledged combinationally in that cycle. `pc_i` is stored as its return address.
- R6: An interrupt request seen while the stack is full is not acknowledged. It stays pending with `irq_i` low and is acknowledged in the first free, request-less cycle after a return has freed a slot.
- R7: A return on an empty stack changes nothing. `empty_o` stays 1, `ret_pc_o` keeps the last returned value, and later stores and returns behave normally.
- R8: When `call_i` and `ret_i` are high in the same cycle, only the return happens and the call's address is never stored.
- R9: An interrupt request coinciding with a call or a return is not acknowledged in that cycle. It becomes pending and is acknowledged in the next cycle that has no call, no return and free space.
- R10: `irq_ack_o` is never 1 while `full_o` is 1. Each pending request yields exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Subroutine call: store `pc_i` |
| irq_i | input | 1 | Unmasked interrupt request |
| ret_i | input | 1 | Return (subroutine or interrupt): restore newest address |
| pc_i | input | 13 | Program counter to store |
| ret_pc_o | output | 13 | Last restored return address |
| irq_ack_o | output | 1 | Interrupt accepted this cycle (address stored) |
| full_o | output | 1 | All eight slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The hardest state to reach from the ports is a held interrupt that is released later. It needs a full stack, an interrupt pulse that is then dropped, idle cycles, and a return. Even in the return cycle the acknowledge must stay low; it may only rise in the cycle after. The bench fills the stack with calls, pulses `irq_i` once, and waits with the request low. It then issues a single return and watches for exactly one acknowledge on the next idle cycle. The address stored by that acknowledge must be the first one returned afterwards.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_PC_W  = 13;

    // Operation selected for the current cycle
    typedef enum logic [1:0] {
        OP_IDLE     = 2'd0,
        OP_PUSH_CALL = 2'd1,
        OP_PUSH_IRQ = 2'd2,
        OP_POP      = 2'd3
    } stk_op_e;

    function automatic logic op_is_push(stk_op_e op);
        return (op == OP_PUSH_CALL) || (op == OP_PUSH_IRQ);
    endfunction

    // Circular successor of a slot index for an arbitrary depth
    function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/ras_arbiter.sv
module ras_arbiter
    import ras_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    call_i,
    input  logic    irq_i,
    input  logic    ret_i,
    input  logic    full_i,
    output stk_op_e op_o,
    output logic    ack_o
);

    logic pend_q;
    logic want_irq;

    assign want_irq = irq_i | pend_q;

    // Return first, then call, then interrupt if a slot is free
    always_comb begin
        if (ret_i)
            op_o = OP_POP;
        else if (call_i)
            op_o = OP_PUSH_CALL;
        else if (want_irq && !full_i)
            op_o = OP_PUSH_IRQ;
        else
            op_o = OP_IDLE;
    end

    assign ack_o = (op_o == OP_PUSH_IRQ);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= want_irq & ~ack_o;
    end

    AST_ACK_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !full_i);                                    // R10
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack_o) |=> pend_q);                        // R6
    AST_IRQ_DEFER: assert property (@(posedge clk) disable iff (rst)
        (irq_i && !ack_o) |=> pend_q);                         // R9
    AST_ACK_ONCE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !pend_q);                                    // R10

endmodule

// File: rtl/ras_pointer.sv
module ras_pointer #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [IDX_W-1:0] top_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [IDX_W-1:0] top_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_prev;

    assign full_o   = (cnt_q == CNT_W'(DEPTH));
    assign empty_o  = (cnt_q == '0);
    assign top_o    = top_q;
    assign wr_idx_o = IDX_W'(ras_pkg::wrap_next(32'(top_q), DEPTH));
    assign top_prev = (top_q == '0) ? IDX_W'(DEPTH - 1) : top_q - IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= IDX_W'(DEPTH - 1);
            cnt_q <= '0;
        end else if (pop_i) begin
            if (!empty_o) begin
                top_q <= top_prev;
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end else if (push_i) begin
            top_q <= wr_idx_o;
            if (!full_o)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
        !(push_i && pop_i));                                   // R8
    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !empty_o) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R2
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o) |=> (empty_o && $stable(top_q)));   // R7
    AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> full_o);                        // R4

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PC_W  = 13,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wr_pc_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_pc_o
);

    logic [PC_W-1:0] slot_q [DEPTH];

    // One register per slot, each with its own write strobe
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (sel)
                slot_q[g] <= wr_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_pc_o <= '0;
        else if (rd_en_i)
            rd_pc_o <= slot_q[rd_idx_i];
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_pc_o));                        // R7

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned PC_W  = DEF_PC_W,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            call_i,
    input  logic            irq_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] ret_pc_o,
    output logic            irq_ack_o,
    output logic            full_o,
    output logic            empty_o
);

    stk_op_e          op;
    logic             do_push;
    logic             do_pop;
    logic             rd_valid;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    ras_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_i),
        .irq_i  (irq_i),
        .ret_i  (ret_i),
        .full_i (full_o),
        .op_o   (op),
        .ack_o  (irq_ack_o)
    );

    assign do_push  = op_is_push(op);
    assign do_pop   = (op == OP_POP);
    assign rd_valid = do_pop & ~empty_o;

    ras_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .push_i   (do_push),
        .pop_i    (do_pop),
        .top_o    (top_idx),
        .wr_idx_o (wr_idx),
        .full_o   (full_o),
        .empty_o  (empty_o)
    );

    ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (do_push),
        .wr_idx_i (wr_idx),
        .wr_pc_i  (pc_i),
        .rd_en_i  (rd_valid),
        .rd_idx_i (top_idx),
        .rd_pc_o  (ret_pc_o)
    );

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));                                 // R3
    AST_RET_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (ret_i || call_i) |-> !irq_ack_o);                     // R9

endmodule

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;

    localparam int PC_W = 13;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            call_i = 1'b0, irq_i = 1'b0, ret_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic [PC_W-1:0] ret_pc_o;
    logic            irq_ack_o, full_o, empty_o;

    ret_addr_stack dut (
        .clk(clk), .rst(rst), .call_i(call_i), .irq_i(irq_i), .ret_i(ret_i),
        .pc_i(pc_i), .ret_pc_o(ret_pc_o), .irq_ack_o(irq_ack_o),
        .full_o(full_o), .empty_o(empty_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int              cyc;
        logic [PC_W-1:0] pc;
        bit              full;
        bit              empty;
        string           tag;
    } item_t;

    item_t           exp_q[$];
    int              checks = 0;
    int              fails = 0;
    int              cyc = 0;
    int unsigned     mstk[$];
    bit              mpend = 0;
    logic [PC_W-1:0] mlast = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare what the design shows after each edge
    always @(posedge clk) begin
        #2;
        while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            check(it.tag, "ret_pc_o", int'(ret_pc_o), int'(it.pc));
            check(it.tag, "full_o", int'(full_o), int'(it.full));
            check(it.tag, "empty_o", int'(empty_o), int'(it.empty));
        end
    end

    // Driver: apply one cycle of requests, update the reference model
    task automatic step(bit c, bit i, bit r, logic [PC_W-1:0] pc, string tag);
        bit    exp_ack;
        item_t it;
        @(negedge clk);
        call_i = c; irq_i = i; ret_i = r; pc_i = pc;
        exp_ack = (i || mpend) && (mstk.size() < DEPTH) && !c && !r;
        #1;
        check(tag, "irq_ack_o", int'(irq_ack_o), int'(exp_ack));
        if (r) begin
            if (mstk.size() > 0) mlast = PC_W'(mstk.pop_back());
        end else if (c || exp_ack) begin
            if (mstk.size() == DEPTH) void'(mstk.pop_front());
            mstk.push_back(int'(pc));
        end
        mpend = (i || mpend) && !exp_ack;
        it.cyc = cyc + 1; it.pc = mlast;
        it.full = (mstk.size() == DEPTH); it.empty = (mstk.size() == 0);
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        check("R1", "ret_pc_o", int'(ret_pc_o), 0);
        check("R1", "empty_o", int'(empty_o), 1);
        check("R1", "full_o", int'(full_o), 0);
        check("R1", "irq_ack_o", int'(irq_ack_o), 0);

        // R2 LIFO order
        for (int k = 1; k <= 3; k++) step(1, 0, 0, PC_W'(13'h100 + k), "R2");
        for (int k = 0; k < 3; k++) step(0, 0, 1, '0, "R2");

        // R3 fill to full, R4 overflow drops the oldest
        for (int k = 0; k < 8; k++) step(1, 0, 0, PC_W'(13'h200 + k), "R3");
        step(1, 0, 0, 13'h1AA, "R4");
        step(1, 0, 0, 13'h1AB, "R4");
        for (int k = 0; k < 8; k++) step(0, 0, 1, '0, "R4");

        // R7 return on empty
        step(0, 0, 1, '0, "R7");
        step(0, 0, 1, '0, "R7");
        step(1, 0, 0, 13'h077, "R7");
        step(0, 0, 1, '0, "R7");

        // R5 immediate acknowledge
        step(0, 1, 0, 13'h0A5, "R5");
        step(0, 0, 1, '0, "R5");

        // R6 held interrupt on a full stack, released after a return
        for (int k = 0; k < 8; k++) step(1, 0, 0, PC_W'(13'h300 + k), "R6");
        step(0, 1, 0, 13'h0DD, "R6");
        step(0, 0, 0, 13'h0DE, "R6");
        step(0, 0, 0, 13'h0DF, "R6");
        step(0, 0, 1, '0, "R6");
        step(0, 0, 0, 13'h0EE, "R6");
        step(0, 0, 0, 13'h0EF, "R10");
        for (int k = 0; k < 8; k++) step(0, 0, 1, '0, "R6");

        // R8 call and return together
        step(1, 0, 0, 13'h050, "R8");
        step(1, 0, 1, 13'h060, "R8");
        step(0, 0, 1, '0, "R8");

        // R9 interrupt colliding with call, then with return
        step(1, 1, 0, 13'h111, "R9");
        step(0, 0, 0, 13'h222, "R9");
        step(0, 1, 1, 13'h333, "R9");
        step(0, 0, 0, 13'h444, "R9");
        step(0, 0, 0, 13'h555, "R10");
        for (int k = 0; k < 3; k++) step(0, 0, 1, '0, "R9");

        step(0, 0, 0, '0, "R10");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R2", "pending items", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule